// File: doc/BRIEF.md
# Column-Partitioned Thermometer-to-Binary Encoder

This block turns the output word of a bank of comparators into a binary output code. The comparator word is a thermometer: for an input at level L, bits 0 to L-1 are set and every higher bit is clear. The word is captured on a convert strobe. A majority filter removes isolated flipped bits. The cleaned word is then split into equal columns. Each column reports the position of its own 1-to-0 edge as a fine code. The index of the column that holds the edge supplies the upper bits of the result.

Two static controls set the output coding. One inverts only the most significant code bit and the other inverts all the lower bits. Together they give plain binary, offset (two's complement) binary, and the inverted form of each. When the top comparator fires, an overrange flag rises and every code bit is driven high. A ready strobe of selectable polarity marks each cycle that carries a fresh result.

Top module: `thermo_col_enc`

## Requirements
- R1: While reset is held, and after reset until the first converted sample arrives, code_o is all zeros, ovr_o is 0 and rdy_o equals rdy_inv_i.
- R2: With both inversion controls at 0, an ideal thermometer of L set bits (bits 0..L-1, L from 0 to N_COMP-1) gives code_o equal to L, with ovr_o at 0.
- R3: msb_inv_i at 1 inverts only code_o bit OUT_B-1. With lsb_inv_i at 0 this gives two's complement, so level 0 reads 0x80 and level 255 reads 0x7F.
- R4: lsb_inv_i at 1 inverts code_o bits OUT_B-2 down to 0. With msb_inv_i at 1 as well this gives inverted binary. With msb_inv_i at 0 it gives inverted two's complement, so level 0 reads 0x7F.
- R5: When the top comparator bit is set together with the bit just below it, ovr_o is 1 and code_o is all ones under every inversion setting. When the top bit is clear, ovr_o is 0.
- R6: A sample is taken at a rising edge where conv_i is 1. Its result appears on the outputs after the next rising edge. The ready strobe is active for exactly that one cycle per sample and is inactive otherwise. code_o and ovr_o hold their values while no sample is in flight.
- R7: rdy_o is the internal valid flag XORed with rdy_inv_i, so with rdy_inv_i at 1 the strobe is active low.
- R8: A thermometer word with any single bit flipped decodes to a level within 1 of the ideal level. This includes flips next to the edge and flips into or out of overrange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_i | input | 1 | Convert strobe: capture therm_i at this edge |
| therm_i | input | N_COMP (256) | Comparator word, bit 0 at the lowest tap |
| msb_inv_i | input | 1 | Invert the most significant code bit |
| lsb_inv_i | input | 1 | Invert all lower code bits |
| rdy_inv_i | input | 1 | Polarity of rdy_o (1 = active low) |
| code_o | output | OUT_B (8) | Output code |
| ovr_o | output | 1 | Overrange flag |
| rdy_o | output | 1 | Result-ready strobe |

## Verification
The bench builds the block at its defaults: N_COMP=256, N_COL=4 and BUBBLE_FIX=1. This lets it sweep all 257 input levels under each of the four codings, and every column boundary (63/64, 127/128, 191/192) and the overrange step are crossed. It then flips each bit from two below to one above the edge at every level, which covers filter behaviour at the lowest bit, at column seams and at the top comparator. Finally it repeats part of the sweep with the ready strobe inverted.

// File: rtl/thermo_col_pkg.sv
package thermo_col_pkg;

   // output coding controls, bundled
   typedef struct packed {
      logic msb_inv;
      logic lsb_inv;
   } coding_t;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   // XOR mask that realises a coding on an OB-bit code (OB <= 32)
   function automatic logic [31:0] coding_mask(input coding_t c, input int ob);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < ob - 1; i++) m[i] = c.lsb_inv;
      m[ob-1] = c.msb_inv;
      return m;
   endfunction

endpackage

// File: rtl/thermo_bubble_fix.sv
module thermo_bubble_fix #(
   parameter int N_COMP = 256,
   parameter bit FIX_EN = 1'b1
) (
   input  logic [N_COMP-1:0] raw_i,
   output logic [N_COMP-1:0] cln_o
);

   generate
      if (FIX_EN) begin : g_vote
         // below the lowest tap reads as 1, above the top tap as 0
         logic [N_COMP+1:0] ext;
         assign ext = {1'b0, raw_i, 1'b1};
         for (genvar k = 0; k < N_COMP; k++) begin : g_bit
            assign cln_o[k] = (ext[k] & ext[k+1]) |
                              (ext[k] & ext[k+2]) |
                              (ext[k+1] & ext[k+2]);
         end
      end else begin : g_pass
         assign cln_o = raw_i;
      end
   endgenerate

endmodule

// File: rtl/thermo_col_prio.sv
module thermo_col_prio #(
   parameter int COL_W  = 64,
   localparam int FINE_B = $clog2(COL_W)
) (
   input  logic [COL_W-1:0]  seg_i,
   input  logic              below_i,
   output logic              hit_o,
   output logic [FINE_B-1:0] idx_o
);

   logic [COL_W:0]   ext;
   logic [COL_W-1:0] edge_w;

   assign ext = {seg_i, below_i};

   generate
      for (genvar i = 0; i < COL_W; i++) begin : g_edge
         assign edge_w[i] = ext[i] & ~ext[i+1];
      end
   endgenerate

   // topmost edge wins
   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      for (int i = 0; i < COL_W; i++) begin
         if (edge_w[i]) begin
            hit_o = 1'b1;
            idx_o = FINE_B'(i);
         end
      end
   end

endmodule

// File: rtl/thermo_col_merge.sv
module thermo_col_merge #(
   parameter int N_COL  = 4,
   parameter int FINE_B = 6,
   localparam int COARSE_B = $clog2(N_COL),
   localparam int OUT_B    = COARSE_B + FINE_B
) (
   input  logic [N_COL-1:0]        hit_i,
   input  logic [N_COL*FINE_B-1:0] idx_i,
   output logic [OUT_B-1:0]        level_o
);

   always_comb begin
      level_o = '0;
      for (int m = 0; m < N_COL; m++) begin
         if (hit_i[m]) level_o = {COARSE_B'(m), idx_i[m*FINE_B +: FINE_B]};
      end
   end

endmodule

// File: rtl/thermo_col_enc.sv
module thermo_col_enc
   import thermo_col_pkg::*;
#(
   parameter int N_COMP     = 256,
   parameter int N_COL      = 4,
   parameter bit BUBBLE_FIX = 1'b1,
   localparam int OUT_B     = $clog2(N_COMP)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              conv_i,
   input  logic [N_COMP-1:0] therm_i,
   input  logic              msb_inv_i,
   input  logic              lsb_inv_i,
   input  logic              rdy_inv_i,
   output logic [OUT_B-1:0]  code_o,
   output logic              ovr_o,
   output logic              rdy_o
);

   localparam int COL_W  = N_COMP / N_COL;
   localparam int FINE_B = $clog2(COL_W);

   generate
      if (!is_pow2(N_COMP) || !is_pow2(N_COL)) begin : g_err_pow2
         $error("thermo_col_enc: N_COMP and N_COL must be powers of two");
      end
      if (N_COL < 2 || COL_W < 2) begin : g_err_split
         $error("thermo_col_enc: need at least two columns of two bits");
      end
      if (OUT_B > 32) begin : g_err_wide
         $error("thermo_col_enc: output code wider than 32 bits");
      end
   endgenerate

   // capture stage
   logic [N_COMP-1:0] therm_q;
   logic              cap_vld_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         therm_q   <= '0;
         cap_vld_q <= 1'b0;
      end else begin
         cap_vld_q <= conv_i;
         if (conv_i) therm_q <= therm_i;
      end
   end

   // bubble filter
   logic [N_COMP-1:0] cln;

   thermo_bubble_fix #(
      .N_COMP (N_COMP),
      .FIX_EN (BUBBLE_FIX)
   ) fix_i (
      .raw_i (therm_q),
      .cln_o (cln)
   );

   // per-column fine encoders
   logic [N_COMP:0]         cln_ext;
   logic [N_COL-1:0]        col_hit;
   logic [N_COL*FINE_B-1:0] col_idx;

   assign cln_ext = {cln, 1'b1};

   generate
      for (genvar m = 0; m < N_COL; m++) begin : g_col
         thermo_col_prio #(
            .COL_W (COL_W)
         ) prio_i (
            .seg_i   (cln_ext[m*COL_W+1 +: COL_W]),
            .below_i (cln_ext[m*COL_W]),
            .hit_o   (col_hit[m]),
            .idx_o   (col_idx[m*FINE_B +: FINE_B])
         );
      end
   endgenerate

   // coarse selection
   logic [OUT_B-1:0] level;

   thermo_col_merge #(
      .N_COL  (N_COL),
      .FINE_B (FINE_B)
   ) merge_i (
      .hit_i   (col_hit),
      .idx_i   (col_idx),
      .level_o (level)
   );

   // coding and output stage
   coding_t          coding;
   logic [31:0]      mask_full;
   logic [OUT_B-1:0] inv_mask;
   logic             top_hit;

   assign coding    = '{msb_inv: msb_inv_i, lsb_inv: lsb_inv_i};
   assign mask_full = coding_mask(coding, OUT_B);
   assign inv_mask  = mask_full[OUT_B-1:0];
   assign top_hit   = cln[N_COMP-1];

   logic [OUT_B-1:0] code_q;
   logic             ovr_q;
   logic             vld_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         code_q <= '0;
         ovr_q  <= 1'b0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= cap_vld_q;
         if (cap_vld_q) begin
            ovr_q  <= top_hit;
            code_q <= top_hit ? '1 : (level ^ inv_mask);
         end
      end
   end

   assign code_o = code_q;
   assign ovr_o  = ovr_q;
   assign rdy_o  = vld_q ^ rdy_inv_i;

   logic unused_mask;
   assign unused_mask = ^mask_full;

endmodule

// File: rtl/thermo_col_enc_chk.sv
module thermo_col_enc_chk #(
   parameter int OUT_B = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             conv_i,
   input logic [1:0]       top2_i,
   input logic             cap_vld_i,
   input logic [OUT_B-1:0] code_i,
   input logic             ovr_i,
   input logic             rdy_i,
   input logic             rdy_inv_i
);

   AST_OVR_ALL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovr_i |-> (&code_i)); // R5

   AST_OVR_RISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (conv_i && (&top2_i)) |-> ##2 ovr_i); // R5

   AST_OVR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (conv_i && !top2_i[1]) |-> ##2 !ovr_i); // R5

   AST_RDY_AFTER_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
      conv_i |-> ##2 (rdy_i ^ rdy_inv_i)); // R6

   AST_RDY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !conv_i |-> ##2 !(rdy_i ^ rdy_inv_i)); // R7

   AST_HOLD_NO_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cap_vld_i |=> ($stable(code_i) && $stable(ovr_i))); // R6

endmodule

bind thermo_col_enc thermo_col_enc_chk #(
   .OUT_B (OUT_B)
) chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .conv_i    (conv_i),
   .top2_i    (therm_i[N_COMP-1 -: 2]),
   .cap_vld_i (cap_vld_q),
   .code_i    (code_o),
   .ovr_i     (ovr_o),
   .rdy_i     (rdy_o),
   .rdy_inv_i (rdy_inv_i)
);

// File: tb/thermo_col_enc_tb_top.sv
module thermo_col_enc_tb_top;

   localparam int CLK_P = 10;
   localparam int N     = 256;
   localparam int OB    = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          conv;
   logic [N-1:0]  therm;
   logic          mi, li, rinv;
   logic [OB-1:0] code;
   logic          ovr, rdy;

   always #(CLK_P/2) clk = ~clk;

   thermo_col_enc dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .conv_i    (conv),
      .therm_i   (therm),
      .msb_inv_i (mi),
      .lsb_inv_i (li),
      .rdy_inv_i (rinv),
      .code_o    (code),
      .ovr_o     (ovr),
      .rdy_o     (rdy)
   );

   typedef struct {
      int lvl;
      bit tol;
      bit mi;
      bit li;
      int cyc;
   } exp_t;

   exp_t sbq[$];
   int   checks = 0;
   int   errors = 0;
   int   cyc    = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   function automatic logic [N-1:0] therm_of(input int lvl);
      logic [N-1:0] w;
      w = '0;
      for (int k = 0; k < N; k++) if (k < lvl) w[k] = 1'b1;
      return w;
   endfunction

   // driver: pushes expected items
   task automatic send(input int lvl, input int flip);
      logic [N-1:0] w;
      w = therm_of(lvl);
      if (flip >= 0) w[flip] = ~w[flip];
      @(negedge clk);
      conv  = 1'b1;
      therm = w;
      sbq.push_back('{lvl: lvl, tol: (flip >= 0), mi: mi, li: li, cyc: cyc});
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         conv = 1'b0;
      end
   endtask

   // monitor: pops and compares
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n === 1'b1 && (rdy ^ rinv)) begin
            if (sbq.size() == 0) begin
               check(1'b0, "R6", "ready with no sample", 1, 0);
            end else begin
               exp_t          e;
               logic [OB-1:0] mask;
               int            got;
               int            diff;
               string         tag;
               e    = sbq.pop_front();
               mask = {e.mi, {(OB-1){e.li}}};
               check(cyc == e.cyc + 2, "R6", "latency", cyc - e.cyc, 2);
               if (ovr) begin
                  got = N;
                  check(code == '1, "R5", "overrange code", int'(code), 255);
               end else begin
                  got = int'(code ^ mask);
               end
               if (e.lvl == N)          tag = "R5";
               else if (!e.mi && !e.li) tag = "R2";
               else if (!e.li)          tag = "R3";
               else                     tag = "R4";
               if (e.tol) begin
                  diff = (got > e.lvl) ? got - e.lvl : e.lvl - got;
                  check(diff <= 1, "R8", "bubble level", got, e.lvl);
               end else begin
                  check(got == e.lvl, tag, "level", got, e.lvl);
               end
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      conv  = 1'b0;
      therm = '0;
      mi    = 1'b0;
      li    = 1'b0;
      rinv  = 1'b0;
      repeat (3) @(negedge clk);
      check(code == '0, "R1", "code in reset", int'(code), 0);
      check(ovr == 1'b0, "R1", "ovr in reset", int'(ovr), 0);
      check(rdy == 1'b0, "R1", "rdy in reset", int'(rdy), 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(3);
      check(rdy == 1'b0 && code == '0, "R1", "idle after reset", int'(rdy), 0);

      // full sweep, four codings
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         mi = c[1];
         li = c[0];
         idle(2);
         for (int lvl = 0; lvl <= N; lvl++) send(lvl, -1);
         idle(4);
      end

      // code hold while idle (R6)
      begin
         logic [OB-1:0] held;
         held = code;
         idle(5);
         check(code == held, "R6", "code held while idle", int'(code), int'(held));
      end

      // single flipped bits around every edge
      @(negedge clk);
      mi = 1'b0;
      li = 1'b0;
      idle(2);
      for (int lvl = 0; lvl <= N; lvl++) begin
         for (int d = -2; d <= 1; d++) begin
            if (lvl + d >= 0 && lvl + d < N) send(lvl, lvl + d);
         end
      end
      idle(4);

      // inverted ready polarity (R7)
      @(negedge clk);
      rinv = 1'b1;
      mi   = 1'b1;
      idle(3);
      check(rdy == 1'b1, "R7", "inverted idle level", int'(rdy), 1);
      for (int lvl = 60; lvl <= 70; lvl++) send(lvl, -1);
      send(N, -1);
      idle(4);
      check(rdy == 1'b1, "R7", "inverted idle after burst", int'(rdy), 1);
      check(sbq.size() == 0, "R6", "results outstanding", sbq.size(), 0);

      summary();
      $finish;
   end

endmodule